// File: doc/BRIEF.md
# Eight-Word Serial Data Queue with Wrapping Level Field

This block is a synchronous first-in first-out queue of eight 9-bit words. A serial controller uses one copy on its transmit path and one on its receive path. A producer writes a word with a one-cycle push strobe. A consumer sees the oldest word on the read data output and removes it with a one-cycle pop strobe.

The fill level is reported in a 3-bit field, so it wraps to zero when all eight slots are occupied. A separate full flag separates that case from an empty queue. A data-available flag and a half-full flag complete the status set. A push into a full queue or a pop from an empty queue is dropped, and a single error pulse reports it. An enable input gates all push and pop traffic. A synchronous clear empties the queue, and it raises a busy error pulse if it discarded words that had not been read.

Top module: `ser_fifo`

## Requirements
- R1: After reset the queue is empty: `level`=0, `full`=0, `half_full`=0, `data_avail`=0, `err`=0, `busy_err`=0.
- R2: Words leave in the order they were accepted. Whenever `data_avail` is 1, `pop_data` shows the oldest held word without waiting for a clock edge.
- R3: `level` holds the number of held words modulo 8 (3 bits). With eight words held, `level` reads 0 and `full` is 1.
- R4: `half_full` is 1 exactly when four or more words are held.
- R5: A push into a full queue without a pop in the same cycle is dropped and leaves the contents unchanged. `err` is 1 for the single cycle after it.
- R6: A pop from an empty queue is dropped, and `err` is 1 for the single cycle after it. A push in that same cycle is still accepted.
- R7: A push and a pop in the same cycle on a full queue are both accepted. `full` stays 1, `level` stays 0, and the pushed word becomes the newest.
- R8: While `fifo_en` is 0, `push` and `pop` have no effect on contents or flags and never raise `err`.
- R9: `soft_clr` empties the queue regardless of `fifo_en`, and a push or pop in the same cycle is dropped. `busy_err` is 1 for the single cycle after a clear that found words held, and stays 0 after a clear of an empty queue.
- R10: `data_avail` is 1 exactly when at least one word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Enables push and pop |
| soft_clr | input | 1 | Synchronous clear of all contents |
| push | input | 1 | Write strobe |
| push_data | input | 9 | Word to write |
| pop | input | 1 | Read strobe, removes the oldest word |
| pop_data | output | 9 | Oldest held word |
| level | output | 3 | Held-word count modulo 8 |
| half_full | output | 1 | Four or more words held |
| full | output | 1 | Eight words held |
| data_avail | output | 1 | At least one word held |
| err | output | 1 | Pulse after a dropped push or pop |
| busy_err | output | 1 | Pulse after a clear that discarded words |

## Verification
The queue is driven with a partial fill followed by a partial drain. This separates correct ordering from a stuck or reversed read pointer. The queue is then filled to eight and pushed again, once alone and once together with a pop, which tells the level wrap, the full flag, the dropped-word rule and the full-queue exchange apart. A full drain followed by pops on the empty queue, with and without a push in the same cycle, shows the empty-side error and that the push still lands. Disabled traffic and clears of a loaded and an empty queue check that the gate leaves all state alone and that the busy error depends on the contents.

// File: rtl/ser_fifo_pkg.sv
package ser_fifo_pkg;

  // Per-cycle decision made by the request arbiter
  typedef struct packed {
    logic wr_go;   // a word is written this cycle
    logic rd_go;   // a word is removed this cycle
    logic bad;     // a request was dropped for lack of room or data
    logic wipe;    // contents are cleared this cycle
  } req_dec_t;

endpackage

// File: rtl/ser_fifo_arb.sv
module ser_fifo_arb
  import ser_fifo_pkg::*;
(
  input  logic     fifo_en,
  input  logic     soft_clr,
  input  logic     push,
  input  logic     pop,
  input  logic     is_full,
  input  logic     is_empty,
  output req_dec_t dec
);

  logic rd_ok;
  logic wr_ok;

  always_comb begin
    rd_ok     = fifo_en && pop && !is_empty;
    wr_ok     = fifo_en && push && (!is_full || rd_ok);
    dec.wipe  = soft_clr;
    dec.rd_go = rd_ok && !soft_clr;
    dec.wr_go = wr_ok && !soft_clr;
    dec.bad   = !soft_clr && fifo_en &&
                ((push && !wr_ok) || (pop && !rd_ok));
  end

endmodule

// File: rtl/ser_fifo_ptrs.sv
module ser_fifo_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             rd_go,
  input  logic             wipe,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] held
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_idx_nxt;
  logic [PTR_W-1:0] rd_idx_nxt;
  logic [CNT_W-1:0] held_nxt;
  logic             upd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_idx_nxt = wr_idx;
    rd_idx_nxt = rd_idx;
    held_nxt   = held;
    upd        = wipe || wr_go || rd_go;
    if (wipe) begin
      wr_idx_nxt = '0;
      rd_idx_nxt = '0;
      held_nxt   = '0;
    end else begin
      if (wr_go) wr_idx_nxt = bump(wr_idx);
      if (rd_go) rd_idx_nxt = bump(rd_idx);
      if (wr_go && !rd_go) held_nxt = held + 1'b1;
      else if (rd_go && !wr_go) held_nxt = held - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      held   <= '0;
    end else if (upd) begin
      wr_idx <= wr_idx_nxt;
      rd_idx <= rd_idx_nxt;
      held   <= held_nxt;
    end
  end

endmodule

// File: rtl/ser_fifo_store.sv
module ser_fifo_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_go,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_go && (wr_idx == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot[g] <= wr_word;
    end
  end

  assign rd_word = slot[rd_idx];

endmodule

// File: rtl/ser_fifo_stat.sv
module ser_fifo_stat #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] held,
  input  logic             bad,
  input  logic             wipe,
  output logic [LVL_W-1:0] level,
  output logic             half_full,
  output logic             full,
  output logic             data_avail,
  output logic             err,
  output logic             busy_err
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic err_nxt;
  logic busy_nxt;

  // narrow field wraps to zero at a full queue
  assign level      = held[LVL_W-1:0];
  assign full       = (held == FULL_CNT);
  assign half_full  = (held >= HALF_CNT);
  assign data_avail = (held != '0);

  always_comb begin
    err_nxt  = bad;
    busy_nxt = wipe && (held != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      err      <= err_nxt;
      busy_err <= busy_nxt;
    end
  end

endmodule

// File: rtl/ser_fifo.sv
module ser_fifo
  import ser_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 9,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              soft_clr,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic              half_full,
  output logic              full,
  output logic              data_avail,
  output logic              err,
  output logic              busy_err
);

  req_dec_t         dec;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;
  logic [CNT_W-1:0] held;

  ser_fifo_arb u_arb (
    .fifo_en  (fifo_en),
    .soft_clr (soft_clr),
    .push     (push),
    .pop      (pop),
    .is_full  (full),
    .is_empty (!data_avail),
    .dec      (dec)
  );

  ser_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_go  (dec.wr_go),
    .rd_go  (dec.rd_go),
    .wipe   (dec.wipe),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .held   (held)
  );

  ser_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_go   (dec.wr_go),
    .wr_idx  (wr_idx),
    .wr_word (push_data),
    .rd_idx  (rd_idx),
    .rd_word (pop_data)
  );

  ser_fifo_stat #(.DEPTH(DEPTH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .held       (held),
    .bad        (dec.bad),
    .wipe       (dec.wipe),
    .level      (level),
    .half_full  (half_full),
    .full       (full),
    .data_avail (data_avail),
    .err        (err),
    .busy_err   (busy_err)
  );

endmodule

// File: rtl/ser_fifo_chk.sv
module ser_fifo_chk #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 9,
  localparam int LVL_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_en,
  input logic              soft_clr,
  input logic              push,
  input logic              pop,
  input logic [WORD_W-1:0] pop_data,
  input logic [LVL_W-1:0]  level,
  input logic              half_full,
  input logic              full,
  input logic              data_avail,
  input logic              err,
  input logic              busy_err
);

  assert_full_level_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == '0) && data_avail);

  assert_full_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half_full);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !soft_clr && full && push && !pop) |=> full && err);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !soft_clr && !data_avail && pop && !push) |=> !data_avail && err);

  assert_swap_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !soft_clr && full && push && pop) |=> full && !err);

  assert_gate_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !soft_clr) |=> $stable(level) && $stable(full) && !err);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !data_avail && !full && !err);

  assert_clear_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && data_avail) |=> busy_err);

endmodule

bind ser_fifo ser_fifo_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .soft_clr   (soft_clr),
  .push       (push),
  .pop        (pop),
  .pop_data   (pop_data),
  .level      (level),
  .half_full  (half_full),
  .full       (full),
  .data_avail (data_avail),
  .err        (err),
  .busy_err   (busy_err)
);

// File: tb/ser_fifo_test.sv
`timescale 1ns/1ps
module ser_fifo_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic       soft_clr;
  logic       push;
  logic [8:0] push_data;
  logic       pop;
  logic [8:0] pop_data;
  logic [2:0] level;
  logic       half_full;
  logic       full;
  logic       data_avail;
  logic       err;
  logic       busy_err;

  int total = 0;
  int bad   = 0;
  logic [8:0] q[$];
  logic       exp_err;
  logic       exp_busy;

  always #10 clk = ~clk;

  ser_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .soft_clr(soft_clr),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .level(level), .half_full(half_full), .full(full),
    .data_avail(data_avail), .err(err), .busy_err(busy_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    int n = q.size();
    chk(level == 3'(n % 8), {tag, " R3 level"}, level, n % 8);
    chk(full == (n == 8), {tag, " R3 full"}, full, n == 8);
    chk(half_full == (n >= 4), {tag, " R4 half_full"}, half_full, n >= 4);
    chk(data_avail == (n != 0), {tag, " R10 data_avail"}, data_avail, n != 0);
    if (n != 0) chk(pop_data == q[0], {tag, " R2 pop_data"}, pop_data, q[0]);
    chk(err == exp_err, {tag, " R5/R6 err"}, err, exp_err);
    chk(busy_err == exp_busy, {tag, " R9 busy_err"}, busy_err, exp_busy);
  endtask

  // one clock with the given requests; updates the expected model from the requirements
  task automatic cyc(input bit en, input bit clr, input bit ps, input bit pp,
                     input logic [8:0] d, input string tag);
    bit rd_ok, wr_ok;
    fifo_en = en; soft_clr = clr; push = ps; pop = pp; push_data = d;
    exp_err = 1'b0; exp_busy = 1'b0;
    if (clr) begin
      exp_busy = (q.size() != 0);
      q.delete();
    end else if (en) begin
      rd_ok = pp && q.size() != 0;
      wr_ok = ps && (q.size() < 8 || rd_ok);
      exp_err = (ps && !wr_ok) || (pp && !rd_ok);
      if (rd_ok) void'(q.pop_front());
      if (wr_ok) q.push_back(d);
    end
    @(posedge clk); #1;
    fifo_en = 1'b1; soft_clr = 1'b0; push = 1'b0; pop = 1'b0;
    chk_state(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fifo_en = 1'b1; soft_clr = 1'b0; push = 1'b0; pop = 1'b0;
    push_data = '0; exp_err = 0; exp_busy = 0; q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk_state("R1 reset");
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 9'(9'h100 + 37 * i), "R2 fill");
    cyc(1, 0, 0, 1, 0, "R2 pop1");
    cyc(1, 0, 0, 1, 0, "R2 pop2");
  endtask

  task automatic t_full_over();
    while (q.size() < 8) cyc(1, 0, 1, 0, 9'(q.size() * 53 + 7), "R3 fill8");
    cyc(1, 0, 1, 0, 9'h1ff, "R5 overflow");
    cyc(1, 0, 0, 0, 0, "R5 err drops");
  endtask

  task automatic t_swap();
    cyc(1, 0, 1, 1, 9'h0a5, "R7 swap1");
    cyc(1, 0, 1, 1, 9'h15a, "R7 swap2");
  endtask

  task automatic t_drain_under();
    while (q.size() > 0) cyc(1, 0, 0, 1, 0, "R2 drain");
    cyc(1, 0, 0, 1, 0, "R6 underflow");
    cyc(1, 0, 1, 1, 9'h033, "R6 pop+push empty");
    cyc(1, 0, 0, 1, 0, "R6 drain one");
  endtask

  task automatic t_gate();
    cyc(1, 0, 1, 0, 9'h011, "R8 preload");
    cyc(0, 0, 1, 0, 9'h022, "R8 push gated");
    cyc(0, 0, 0, 1, 0, "R8 pop gated");
    cyc(1, 0, 0, 1, 0, "R8 pop after gate");
    cyc(0, 0, 0, 1, 0, "R8 pop gated empty");
  endtask

  task automatic t_clear();
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 9'(i + 80), "R9 load");
    cyc(0, 1, 1, 0, 9'h044, "R9 clear loaded");
    cyc(1, 0, 0, 0, 0, "R9 busy drops");
    cyc(1, 1, 0, 0, 0, "R9 clear empty");
    cyc(1, 0, 1, 0, 9'h0f0, "R9 reuse after clear");
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_full_over();
    t_swap();
    t_drain_under();
    t_gate();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule